// File: doc/BRIEF.md
# Sixteen-Bit ALU with Condition and Control Flags

This block is the arithmetic and logic stage of a small processor datapath. On each cycle in which `op_valid` is high it applies one operation to two operands, at either word (16-bit) or byte (low 8 bits) size. The result is registered, and the six condition flags in a 16-bit flag word are updated from it: carry, parity, nibble carry, zero, sign and overflow. The flag word also holds three control bits: single-step trap, interrupt enable and string direction. These change only through dedicated per-bit set and clear strobes.

The operations are add, subtract, AND, OR, XOR, increment, decrement, one's complement and three single-bit shifts: left, logical right and arithmetic right. The block does no instruction decoding. The surrounding sequencer supplies the operation code and the size select directly.

There is no sequential control state beyond the result and flag registers. The operation code is an enumerated type that drives one `unique case` selection of the result and flag sources.

Top module: `alu_status_unit`

## Requirements
- R1: Both `result` and `flags` reset to 0x0000. A valid operation updates `result` at the first rising edge at which `op_valid` is sampled high. With `byte_mode`=1 only the low 8 bits of the operands are used, and `result[15:8]` is 0.
- R2: The operation codes are 0 add, 1 subtract (a−b), 2 AND, 3 OR, 4 XOR, 5 increment a, 6 decrement a, 7 complement a, 8 shift left, 9 logical shift right and 10 arithmetic shift right. Each gives the result of that operation at the selected size.
- R3: Carry (flag bit 0) is set by add on a carry out of the top bit of the selected size, and by subtract on a borrow out of that bit.
- R4: Parity (flag bit 2) is 1 when `result[7:0]` holds an even number of ones, in both sizes.
- R5: Nibble carry (flag bit 4) is set by add, subtract, increment and decrement on a carry or borrow between bit 3 and bit 4. All other flag-updating operations clear it.
- R6: Zero (flag bit 6) is set when the sized result is all zeros. Sign (flag bit 7) copies the top bit of the sized result.
- R7: Overflow (flag bit 11) is set by add, subtract, increment and decrement when the signed result leaves the range of the selected size.
- R8: AND, OR and XOR clear carry and overflow.
- R9: Increment and decrement leave carry unchanged and ignore `opnd_b`.
- R10: Every shift loads carry with the bit shifted out. Overflow becomes top-result-bit XOR carry for a left shift, the original top bit for a logical right shift, and 0 for an arithmetic right shift.
- R11: Complement updates `result` and leaves every flag unchanged.
- R12: Flag bits 1, 3, 5 and 12 to 15 always read 0.
- R13: Control bits trap (bit 8), interrupt enable (bit 9) and direction (bit 10) are set by `ctl_set[0..2]` and cleared by `ctl_clr[0..2]` respectively, with set winning when both are high. No operation alters them.
- R14: Operation codes 11 to 15, and cycles with `op_valid` low, change neither `result` nor `flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Apply the operation this cycle |
| op_code | input | 4 | Operation select (R2) |
| byte_mode | input | 1 | 1 = byte size, 0 = word size |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| ctl_set | input | 3 | Set strobes: trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear strobes, same bit order |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag word |

## Verification
Addition is tried with operands that produce no carry, a full wrap to zero, a positive-to-negative overflow and a doubled negative. Together these separate carry from overflow and nibble carry from both. Subtraction is run across zero and across the signed minimum, which separates borrow from signed overflow. A byte-size add whose upper operand bytes are nonzero shows that the upper bytes are ignored and that carry and zero are taken at bit 7. Increment is run with carry preset both high and low to show that carry is preserved and not recomputed. Shift patterns with distinct edge bits tell the three overflow rules apart. Set/clear strobe patterns, including a simultaneous set and clear, isolate the control bits from the arithmetic.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_SAR = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_e;

    localparam int FL_CF = 0;
    localparam int FL_PF = 2;
    localparam int FL_AF = 4;
    localparam int FL_ZF = 6;
    localparam int FL_SF = 7;
    localparam int FL_TF = 8;
    localparam int FL_IF = 9;
    localparam int FL_DF = 10;
    localparam int FL_OF = 11;

    localparam int CTL_N = 3;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } cond_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic              sub,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              nib_carry,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   sum_w;
    logic [HALF_W:0]   sum_h;
    logic              cout;
    logic              a_top;
    logic              b_top;
    logic              r_top;

    always_comb begin
        b_x   = b ^ {DATA_W{sub}};
        sum_w = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub};
        sum_h = {1'b0, a[HALF_W-1:0]} + {1'b0, b_x[HALF_W-1:0]}
              + {{HALF_W{1'b0}}, sub};
        if (byte_mode) begin
            sum   = {{(DATA_W-HALF_W){1'b0}}, sum_h[HALF_W-1:0]};
            cout  = sum_h[HALF_W];
            a_top = a[HALF_W-1];
            b_top = b[HALF_W-1];
            r_top = sum_h[HALF_W-1];
        end else begin
            sum   = sum_w[DATA_W-1:0];
            cout  = sum_w[DATA_W];
            a_top = a[DATA_W-1];
            b_top = b[DATA_W-1];
            r_top = sum_w[DATA_W-1];
        end
        // a borrow is the inverse of the two's-complement carry
        carry     = sub ? ~cout : cout;
        nib_carry = a[4] ^ b[4] ^ sum[4];
        if (sub)
            ovf = (a_top != b_top) && (r_top != a_top);
        else
            ovf = (a_top == b_top) && (r_top != a_top);
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  shift_e            kind,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;
    localparam int UP_W   = DATA_W - HALF_W;

    logic [HALF_W-1:0] lo;
    logic              top;

    always_comb begin
        lo  = a[HALF_W-1:0];
        top = byte_mode ? lo[HALF_W-1] : a[DATA_W-1];
        res = '0;
        cout = 1'b0;
        ovf  = 1'b0;
        unique case (kind)
            SH_LEFT: begin
                if (byte_mode) res = {{UP_W{1'b0}}, lo[HALF_W-2:0], 1'b0};
                else           res = {a[DATA_W-2:0], 1'b0};
                cout = top;
                ovf  = (byte_mode ? res[HALF_W-1] : res[DATA_W-1]) ^ top;
            end
            SH_RLOG: begin
                if (byte_mode) res = {{UP_W{1'b0}}, 1'b0, lo[HALF_W-1:1]};
                else           res = {1'b0, a[DATA_W-1:1]};
                cout = a[0];
                ovf  = top;
            end
            SH_RARI: begin
                if (byte_mode) res = {{UP_W{1'b0}}, top, lo[HALF_W-1:1]};
                else           res = {top, a[DATA_W-1:1]};
                cout = a[0];
                ovf  = 1'b0;
            end
            default: begin
                res  = '0;
                cout = 1'b0;
                ovf  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cf_now,
    output logic [DATA_W-1:0] res,
    output cond_t             cond_nx,
    output logic              res_we,
    output logic              cond_we
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic              as_sub;
    logic [DATA_W-1:0] as_b;
    logic [DATA_W-1:0] as_sum;
    logic              as_c;
    logic              as_af;
    logic              as_of;
    shift_e            sh_kind;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              sh_of;
    logic [DATA_W-1:0] size_mask;

    always_comb begin
        as_sub  = (op == OP_SUB) || (op == OP_DEC);
        as_b    = ((op == OP_INC) || (op == OP_DEC)) ? ONE : b;
        unique case (op)
            OP_SHR:  sh_kind = SH_RLOG;
            OP_SAR:  sh_kind = SH_RARI;
            default: sh_kind = SH_LEFT;
        endcase
        size_mask = byte_mode ? BYTE_MASK : {DATA_W{1'b1}};
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .sub       (as_sub),
        .byte_mode (byte_mode),
        .a         (a),
        .b         (as_b),
        .sum       (as_sum),
        .carry     (as_c),
        .nib_carry (as_af),
        .ovf       (as_of)
    );

    alu_shift #(.DATA_W(DATA_W)) u_shift (
        .kind      (sh_kind),
        .byte_mode (byte_mode),
        .a         (a),
        .res       (sh_res),
        .cout      (sh_c),
        .ovf       (sh_of)
    );

    always_comb begin
        res     = '0;
        cond_nx = '0;
        res_we  = 1'b1;
        cond_we = 1'b1;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res        = as_sum;
                cond_nx.cf = as_c;
                cond_nx.af = as_af;
                cond_nx.of = as_of;
            end
            OP_INC, OP_DEC: begin
                res        = as_sum;
                cond_nx.cf = cf_now;
                cond_nx.af = as_af;
                cond_nx.of = as_of;
            end
            OP_AND: res = a & b & size_mask;
            OP_OR:  res = (a | b) & size_mask;
            OP_XOR: res = (a ^ b) & size_mask;
            OP_NOT: begin
                res     = ~a & size_mask;
                cond_we = 1'b0;
            end
            OP_SHL, OP_SHR, OP_SAR: begin
                res        = sh_res;
                cond_nx.cf = sh_c;
                cond_nx.of = sh_of;
            end
            default: begin
                res_we  = 1'b0;
                cond_we = 1'b0;
            end
        endcase
        cond_nx.pf = ~^res[7:0];
        cond_nx.zf = (res == '0);
        cond_nx.sf = byte_mode ? res[HALF_W-1] : res[DATA_W-1];
    end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flags_pkg::*;
#(
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_we,
    input  cond_t             cond_in,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    output logic [FLAG_W-1:0] flags_o
);
    cond_t             cond_q;
    logic [CTL_N-1:0]  ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cond_q <= '0;
        else if (cond_we) cond_q <= cond_in;
    end

    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ctl_q[i] <= 1'b0;
            else if (ctl_set[i]) ctl_q[i] <= 1'b1;
            else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
        end
    end

    always_comb begin
        flags_o        = '0;
        flags_o[FL_CF] = cond_q.cf;
        flags_o[FL_PF] = cond_q.pf;
        flags_o[FL_AF] = cond_q.af;
        flags_o[FL_ZF] = cond_q.zf;
        flags_o[FL_SF] = cond_q.sf;
        flags_o[FL_OF] = cond_q.of;
        for (int i = 0; i < CTL_N; i++)
            flags_o[FL_TF+i] = ctl_q[i];
    end

    // R13
    ctl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_set[0] |=> flags_o[FL_TF]);

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    op_e               op;
    logic [DATA_W-1:0] core_res;
    cond_t             core_cond;
    logic              core_res_we;
    logic              core_cond_we;
    logic              flag_we;
    logic [DATA_W-1:0] result_q;
    logic [FLAG_W-1:0] flags_w;
    logic              is_logic;
    logic              is_step;

    assign op       = op_e'(op_code);
    assign flag_we  = op_valid && core_cond_we;
    assign is_logic = op_valid && ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR));
    assign is_step  = op_valid && ((op == OP_INC) || (op == OP_DEC));

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op        (op),
        .byte_mode (byte_mode),
        .a         (opnd_a),
        .b         (opnd_b),
        .cf_now    (flags_w[FL_CF]),
        .res       (core_res),
        .cond_nx   (core_cond),
        .res_we    (core_res_we),
        .cond_we   (core_cond_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       result_q <= '0;
        else if (op_valid && core_res_we) result_q <= core_res;
    end

    flag_reg #(.FLAG_W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_we (flag_we),
        .cond_in (core_cond),
        .ctl_set (ctl_set),
        .ctl_clr (ctl_clr),
        .flags_o (flags_w)
    );

    assign result = result_q;
    assign flags  = flags_w;

    // R13
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags_w[FL_DF:FL_TF]));

    // R8
    logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (!flags_w[FL_CF] && !flags_w[FL_OF]));

    // R9
    step_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_step |=> (flags_w[FL_CF] == $past(flags_w[FL_CF])));

    // R11
    not_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_NOT) |=> ($stable(flags_w[FL_CF]) && $stable(flags_w[FL_ZF])
                                        && $stable(flags_w[FL_OF]) && $stable(flags_w[FL_PF])));

    // R4
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_w[FL_PF] == ~^result_q[7:0]));

    // R6
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_w[FL_ZF] == (result_q == '0)));

    // R14
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result_q));

endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [2:0]  ctl_set = 3'd0;
    logic [2:0]  ctl_clr = 3'd0;
    logic [15:0] result;
    logic [15:0] flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_status_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .byte_mode (byte_mode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .ctl_set   (ctl_set),
        .ctl_clr   (ctl_clr),
        .result    (result),
        .flags     (flags)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic bm,
                          input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_valid  = 1'b1;
        op_code   = op;
        byte_mode = bm;
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic strobe(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk);
        ctl_set = s;
        ctl_clr = c;
        @(negedge clk);
        ctl_set = 3'd0;
        ctl_clr = 3'd0;
    endtask

    task automatic t_reset;
        chk("R1 reset result", result, 16'h0000);
        chk("R1 reset flags", flags, 16'h0000);
    endtask

    task automatic t_add;
        run_op(4'd0, 1'b0, 16'h1234, 16'h5678);
        chk("R2 add result", result, 16'h68AC);
        chk("R4 add flags", flags, 16'h0004);
        run_op(4'd0, 1'b0, 16'hFFFF, 16'h0001);
        chk("R3 R5 R6 wrap flags", flags, 16'h0055);
        run_op(4'd0, 1'b0, 16'h7FFF, 16'h0001);
        chk("R7 add ovf result", result, 16'h8000);
        chk("R7 add ovf flags", flags, 16'h0894);
        run_op(4'd0, 1'b0, 16'h8000, 16'h8000);
        chk("R3 R7 neg double flags", flags, 16'h0845);
    endtask

    task automatic t_sub;
        run_op(4'd1, 1'b0, 16'h0000, 16'h0001);
        chk("R2 sub result", result, 16'hFFFF);
        chk("R3 sub borrow flags", flags, 16'h0095);
        run_op(4'd1, 1'b0, 16'h8000, 16'h0001);
        chk("R7 sub ovf result", result, 16'h7FFF);
        chk("R7 sub ovf flags", flags, 16'h0814);
    endtask

    task automatic t_byte;
        run_op(4'd0, 1'b1, 16'h12F0, 16'h3410);
        chk("R1 byte add result", result, 16'h0000);
        chk("R1 R3 byte add flags", flags, 16'h0045);
        run_op(4'd0, 1'b1, 16'h007F, 16'h0001);
        chk("R6 R7 byte ovf result", result, 16'h0080);
        chk("R6 R7 byte ovf flags", flags, 16'h0890);
    endtask

    task automatic t_logic;
        run_op(4'd0, 1'b0, 16'h8000, 16'h8000);
        run_op(4'd2, 1'b0, 16'hF0F0, 16'h0FF0);
        chk("R8 and result", result, 16'h00F0);
        chk("R8 and flags", flags, 16'h0004);
        run_op(4'd3, 1'b0, 16'h8001, 16'h0002);
        chk("R2 or result", result, 16'h8003);
        chk("R6 or flags", flags, 16'h0084);
        run_op(4'd4, 1'b0, 16'hAAAA, 16'hAAAA);
        chk("R2 xor result", result, 16'h0000);
        chk("R8 xor flags", flags, 16'h0044);
    endtask

    task automatic t_incdec;
        run_op(4'd0, 1'b0, 16'hFFFF, 16'h0001);
        run_op(4'd5, 1'b0, 16'h00FF, 16'h1234);
        chk("R9 inc result", result, 16'h0100);
        chk("R9 inc keeps cf=1", flags, 16'h0015);
        run_op(4'd4, 1'b0, 16'hAAAA, 16'hAAAA);
        run_op(4'd5, 1'b0, 16'h7FFF, 16'h0000);
        chk("R7 inc ovf flags", flags, 16'h0894);
        run_op(4'd6, 1'b0, 16'h0000, 16'h5555);
        chk("R9 dec result", result, 16'hFFFF);
        chk("R9 dec keeps cf=0", flags, 16'h0094);
        run_op(4'd6, 1'b1, 16'h0080, 16'h0000);
        chk("R7 byte dec result", result, 16'h007F);
        chk("R5 R7 byte dec flags", flags, 16'h0810);
    endtask

    task automatic t_not;
        run_op(4'd7, 1'b0, 16'h0F0F, 16'h0000);
        chk("R11 not result", result, 16'hF0F0);
        chk("R11 not flags kept", flags, 16'h0810);
        run_op(4'd7, 1'b1, 16'hABCD, 16'h0000);
        chk("R11 byte not result", result, 16'h0032);
        chk("R11 byte not flags kept", flags, 16'h0810);
    endtask

    task automatic t_shift;
        run_op(4'd8, 1'b0, 16'h8001, 16'h0000);
        chk("R10 shl result", result, 16'h0002);
        chk("R10 shl flags", flags, 16'h0801);
        run_op(4'd9, 1'b0, 16'h8001, 16'h0000);
        chk("R10 shr result", result, 16'h4000);
        chk("R10 shr flags", flags, 16'h0805);
        run_op(4'd10, 1'b0, 16'h8002, 16'h0000);
        chk("R10 sar result", result, 16'hC001);
        chk("R10 sar flags", flags, 16'h0080);
        run_op(4'd8, 1'b1, 16'h00C0, 16'h0000);
        chk("R10 byte shl result", result, 16'h0080);
        chk("R10 byte shl flags", flags, 16'h0081);
    endtask

    task automatic t_ctl;
        strobe(3'b101, 3'b000);
        chk("R13 set trap+dir", flags & 16'h0700, 16'h0500);
        run_op(4'd0, 1'b0, 16'h0001, 16'h0001);
        chk("R13 op keeps ctl", flags, 16'h0500);
        strobe(3'b000, 3'b001);
        chk("R13 clear trap", flags, 16'h0400);
        strobe(3'b010, 3'b010);
        chk("R13 set wins", flags, 16'h0600);
        strobe(3'b111, 3'b000);
        run_op(4'd0, 1'b0, 16'h8000, 16'h8000);
        chk("R12 full word", flags, 16'h0F45);
        chk("R12 unused bits zero", flags & 16'hF02A, 16'h0000);
    endtask

    task automatic t_idle;
        logic [15:0] r0;
        logic [15:0] f0;
        r0 = result;
        f0 = flags;
        run_op(4'hC, 1'b0, 16'h1111, 16'h2222);
        chk("R14 bad code result", result, r0);
        chk("R14 bad code flags", flags, f0);
        @(negedge clk);
        op_code = 4'd0;
        opnd_a  = 16'h0003;
        opnd_b  = 16'h0004;
        @(negedge clk);
        chk("R14 idle result", result, r0);
        chk("R14 idle flags", flags, f0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_byte();
        t_logic();
        t_incdec();
        t_not();
        t_shift();
        t_ctl();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule